// File: doc/BRIEF.md
# Lockable TLB Region Manager

This block holds the pinned part of a translation lookaside buffer: eight fully associative entries, each mapping a virtual page number tagged with an address-space identifier to a physical page number. Entries get in only through page-walk fills, and only while software has armed the block by setting a preserve bit in a control register. Each fill taken this way goes into the entry named by a victim pointer, and the pointer then moves on to the next entry. Pinned translations survive a bulk flush of unlocked entries. They are still removed by a targeted flush by virtual page or by identifier.

A two-state machine tracks the preserve bit. In `ST_PASS` (preserve clear) fills are sent on to the main array through `fill_to_main`, and the store is left alone. In `ST_CAPTURE` (preserve set) fills are written into the store. The transition `ST_PASS -> ST_CAPTURE` is taken on a register write with bit 0 set. The transition `ST_CAPTURE -> ST_PASS` is taken on a register write with bit 0 clear. Any other cycle stays in the current state. Lookups are combinational and return hit, physical page and entry index.

Top module: `lock_tlb_region`

## Requirements
- R1: After reset all entries are invalid, the control register reads 0 and every lookup misses.
- R2: The control register holds the preserve bit at bit 0 and the victim pointer at bits [28:26]. A write loads both fields on the next edge. A read is combinational, and all other bits read 0.
- R3: With preserve set, a fill (`fill_valid`) writes its page, identifier and physical page into the entry the victim names, and that entry becomes valid on the next edge.
- R4: Each fill written into the store advances the victim by one. From 7 it wraps to 0.
- R5: With preserve clear, a fill raises `fill_to_main` in the same cycle. It leaves the store and the victim unchanged.
- R6: `inv_op` = 2'b01 (flush unlocked) with `inv_valid` leaves every entry valid. 2'b00 does nothing.
- R7: `inv_op` = 2'b10 invalidates every entry whose virtual page equals `inv_vpn`, whatever its identifier.
- R8: `inv_op` = 2'b11 invalidates every entry whose identifier equals `inv_asid`.
- R9: A lookup hits only on a valid entry whose page and identifier both equal the lookup inputs. On a miss, `lk_ppn` and `lk_idx` are 0.
- R10: When several valid entries match, the lowest index supplies the result.
- R11: When a register write and a fill arrive in the same cycle, the fill uses the old preserve bit and victim, and the written victim value wins over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write value |
| reg_rd_data | output | 32 | Control register read value |
| fill_valid | input | 1 | Page-walk fill present |
| fill_vpn | input | VPN_W | Fill virtual page |
| fill_asid | input | ASID_W | Fill identifier |
| fill_ppn | input | PPN_W | Fill physical page |
| fill_to_main | output | 1 | Fill handed to the main array |
| inv_valid | input | 1 | Invalidate command present |
| inv_op | input | 2 | Invalidate kind (01 unlocked, 10 by page, 11 by identifier) |
| inv_vpn | input | VPN_W | Page operand |
| inv_asid | input | ASID_W | Identifier operand |
| lk_vpn | input | VPN_W | Lookup page |
| lk_asid | input | ASID_W | Lookup identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page on hit |
| lk_idx | output | 3 | Entry index on hit |

## Verification
Fills are sent in both states. This shows whether a fill lands in the store or is handed to the main array. Victim values 0, 2, 5 and 7 check that the pointer lands where it was set and that it wraps. The store is loaded with entries that share a page but differ in identifier, and with entries that share an identifier but differ in page. This tells a flush by page apart from a flush by identifier, and both apart from the flush of unlocked entries. Duplicate entries at indices 2 and 5, and a write that coincides with a fill, cover the priority and ordering cases.

// File: rtl/ltr_pkg.sv
package ltr_pkg;
    typedef enum logic [1:0] {
        INV_NONE     = 2'b00,
        INV_UNLOCKED = 2'b01,
        INV_BY_VA    = 2'b10,
        INV_BY_ASID  = 2'b11
    } inv_op_e;

    typedef enum logic {
        ST_PASS    = 1'b0,
        ST_CAPTURE = 1'b1
    } mode_e;

    localparam int unsigned PRESERVE_BIT = 0;
endpackage

// File: rtl/ltr_ctrl.sv
module ltr_ctrl
    import ltr_pkg::*;
#(
    parameter int unsigned ENTRIES  = 8,
    parameter int unsigned VICT_LSB = 26,
    localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [31:0]      reg_wr_data,
    input  logic             fill_valid,
    output logic [IDX_W-1:0] victim,
    output logic             lock_wr,
    output logic             fill_to_main,
    output logic [31:0]      reg_rd_data
);
    mode_e            mode_q, mode_d;
    logic [IDX_W-1:0] victim_q, victim_nx;
    logic             preserve;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ST_PASS;
        else        mode_q <= mode_d;
    end

    // next state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_PASS:    if (reg_wr_en &&  reg_wr_data[PRESERVE_BIT]) mode_d = ST_CAPTURE;
            ST_CAPTURE: if (reg_wr_en && !reg_wr_data[PRESERVE_BIT]) mode_d = ST_PASS;
            default:    mode_d = ST_PASS;
        endcase
    end

    // outputs per state
    always_comb begin
        preserve     = 1'b0;
        lock_wr      = 1'b0;
        fill_to_main = 1'b0;
        unique case (mode_q)
            ST_PASS: begin
                fill_to_main = fill_valid;
            end
            ST_CAPTURE: begin
                preserve = 1'b1;
                lock_wr  = fill_valid;
            end
            default: begin
                fill_to_main = fill_valid;
            end
        endcase
    end

    assign victim_nx = (victim_q == IDX_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;

    // software write has priority over the automatic advance
    always_ff @(posedge clk) begin
        if (!rst_n)         victim_q <= '0;
        else if (reg_wr_en) victim_q <= reg_wr_data[VICT_LSB +: IDX_W];
        else if (lock_wr)   victim_q <= victim_nx;
    end

    always_comb begin
        reg_rd_data                       = '0;
        reg_rd_data[PRESERVE_BIT]         = preserve;
        reg_rd_data[VICT_LSB +: IDX_W]    = victim_q;
    end

    assign victim = victim_q;
endmodule

// File: rtl/ltr_store.sv
module ltr_store
    import ltr_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PPN_W   = 20,
    parameter int unsigned ASID_W  = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [VPN_W-1:0]                 wr_vpn,
    input  logic [ASID_W-1:0]                wr_asid,
    input  logic [PPN_W-1:0]                 wr_ppn,
    input  logic                             inv_valid,
    input  inv_op_e                          inv_op,
    input  logic [VPN_W-1:0]                 inv_vpn,
    input  logic [ASID_W-1:0]                inv_asid,
    output logic [ENTRIES-1:0]               vld_o,
    output logic [ENTRIES-1:0][VPN_W-1:0]    vpn_o,
    output logic [ENTRIES-1:0][ASID_W-1:0]   asid_o,
    output logic [ENTRIES-1:0][PPN_W-1:0]    ppn_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic              v_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic [PPN_W-1:0]  ppn_q;
        logic              sel, kill;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // flushing unlocked entries never touches this store
        always_comb begin
            kill = 1'b0;
            if (inv_valid) begin
                unique case (inv_op)
                    INV_BY_VA:    kill = (vpn_q == inv_vpn);
                    INV_BY_ASID:  kill = (asid_q == inv_asid);
                    INV_UNLOCKED: kill = 1'b0;
                    INV_NONE:     kill = 1'b0;
                    default:      kill = 1'b0;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)    v_q <= 1'b0;
            else if (sel)  v_q <= 1'b1;
            else if (kill) v_q <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                vpn_q  <= wr_vpn;
                asid_q <= wr_asid;
                ppn_q  <= wr_ppn;
            end
        end

        assign vld_o[g]  = v_q;
        assign vpn_o[g]  = vpn_q;
        assign asid_o[g] = asid_q;
        assign ppn_o[g]  = ppn_q;
    end
endmodule

// File: rtl/ltr_lookup.sv
module ltr_lookup #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PPN_W   = 20,
    parameter int unsigned ASID_W  = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [VPN_W-1:0]                 q_vpn,
    input  logic [ASID_W-1:0]                q_asid,
    input  logic [ENTRIES-1:0]               vld_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0]    vpn_i,
    input  logic [ENTRIES-1:0][ASID_W-1:0]   asid_i,
    input  logic [ENTRIES-1:0][PPN_W-1:0]    ppn_i,
    output logic                             hit,
    output logic [IDX_W-1:0]                 idx,
    output logic [PPN_W-1:0]                 ppn
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_i[g] && (vpn_i[g] == q_vpn) && (asid_i[g] == q_asid);
    end

    // scan from the top so the lowest matching index is the last written
    always_comb begin
        hit = 1'b0;
        idx = '0;
        ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
                ppn = ppn_i[i];
            end
        end
    end
endmodule

// File: rtl/lock_tlb_region.sv
module lock_tlb_region
    import ltr_pkg::*;
#(
    parameter int unsigned ENTRIES  = 8,
    parameter int unsigned VPN_W    = 20,
    parameter int unsigned PPN_W    = 20,
    parameter int unsigned ASID_W   = 8,
    parameter int unsigned VICT_LSB = 26,
    localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    output logic [31:0]       reg_rd_data,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    output logic              fill_to_main,
    input  logic              inv_valid,
    input  logic [1:0]        inv_op,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [IDX_W-1:0]  lk_idx
);
    logic [IDX_W-1:0]               victim;
    logic                           lock_wr;
    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
    logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
    logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
    inv_op_e                        inv_kind;

    assign inv_kind = inv_op_e'(inv_op);

    ltr_ctrl #(.ENTRIES(ENTRIES), .VICT_LSB(VICT_LSB)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .fill_valid   (fill_valid),
        .victim       (victim),
        .lock_wr      (lock_wr),
        .fill_to_main (fill_to_main),
        .reg_rd_data  (reg_rd_data)
    );

    ltr_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lock_wr),
        .wr_idx    (victim),
        .wr_vpn    (fill_vpn),
        .wr_asid   (fill_asid),
        .wr_ppn    (fill_ppn),
        .inv_valid (inv_valid),
        .inv_op    (inv_kind),
        .inv_vpn   (inv_vpn),
        .inv_asid  (inv_asid),
        .vld_o     (ent_valid),
        .vpn_o     (ent_vpn),
        .asid_o    (ent_asid),
        .ppn_o     (ent_ppn)
    );

    ltr_lookup #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) lookup_i (
        .q_vpn  (lk_vpn),
        .q_asid (lk_asid),
        .vld_i  (ent_valid),
        .vpn_i  (ent_vpn),
        .asid_i (ent_asid),
        .ppn_i  (ent_ppn),
        .hit    (lk_hit),
        .idx    (lk_idx),
        .ppn    (lk_ppn)
    );
endmodule

// File: rtl/ltr_chk.sv
module ltr_chk #(
    parameter int unsigned ENTRIES  = 8,
    parameter int unsigned VICT_LSB = 26,
    localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [31:0]        reg_wr_data,
    input logic [31:0]        reg_rd_data,
    input logic               fill_valid,
    input logic               fill_to_main,
    input logic               inv_valid,
    input logic [1:0]         inv_op,
    input logic [ENTRIES-1:0] ent_valid,
    input logic               lk_hit,
    input logic [IDX_W-1:0]   lk_idx
);
    logic [IDX_W-1:0] vic;
    logic [IDX_W-1:0] vic_after;
    logic             pres;

    assign vic       = reg_rd_data[VICT_LSB +: IDX_W];
    assign pres      = reg_rd_data[0];
    assign vic_after = (vic == IDX_W'(ENTRIES - 1)) ? '0 : vic + 1'b1;

    // R2
    reg_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data[0] == $past(reg_wr_data[0])) &&
                      (vic == $past(reg_wr_data[VICT_LSB +: IDX_W])));

    // R3
    capture_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pres && fill_valid) |=> ent_valid[$past(vic)]);

    // R4
    victim_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pres && fill_valid && !reg_wr_en) |=> (vic == $past(vic_after)));

    // R5
    pass_leaves_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_to_main && !inv_valid) |=> (ent_valid == $past(ent_valid)));

    // R5
    main_only_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_to_main |-> (!pres && fill_valid));

    // R6
    unlocked_flush_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_op == 2'b01 && !fill_valid) |=> (ent_valid == $past(ent_valid)));

    // R9
    hit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ent_valid[lk_idx]);
endmodule

bind lock_tlb_region ltr_chk #(.ENTRIES(ENTRIES), .VICT_LSB(VICT_LSB)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .reg_rd_data  (reg_rd_data),
    .fill_valid   (fill_valid),
    .fill_to_main (fill_to_main),
    .inv_valid    (inv_valid),
    .inv_op       (inv_op),
    .ent_valid    (ent_valid),
    .lk_hit       (lk_hit),
    .lk_idx       (lk_idx)
);

// File: tb/lock_tlb_region_tb_top.sv
module lock_tlb_region_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic [19:0] fill_ppn;
    logic        fill_to_main;
    logic        inv_valid;
    logic [1:0]  inv_op;
    logic [19:0] inv_vpn;
    logic [7:0]  inv_asid;
    logic [19:0] lk_vpn;
    logic [7:0]  lk_asid;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic [2:0]  lk_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lock_tlb_region dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_ppn(fill_ppn), .fill_to_main(fill_to_main),
        .inv_valid(inv_valid), .inv_op(inv_op), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_idx(lk_idx)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        reg_wr_en = 0; reg_wr_data = '0;
        fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0;
        inv_valid = 0; inv_op = 2'b00; inv_vpn = '0; inv_asid = '0;
    endtask

    task automatic wr_reg(input logic [31:0] v);
        reg_wr_en = 1; reg_wr_data = v;
        tick();
        reg_wr_en = 0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                        input bit exp_main, input string req);
        fill_valid = 1; fill_vpn = v; fill_asid = a; fill_ppn = p;
        #1;
        check(fill_to_main == exp_main, req, 32'(fill_to_main), 32'(exp_main));
        tick();
        fill_valid = 0;
    endtask

    task automatic flush(input logic [1:0] op, input logic [19:0] v, input logic [7:0] a);
        inv_valid = 1; inv_op = op; inv_vpn = v; inv_asid = a;
        tick();
        inv_valid = 0; inv_op = 2'b00;
    endtask

    task automatic look(input logic [19:0] v, input logic [7:0] a, input bit exp_hit,
                        input logic [2:0] exp_idx, input logic [19:0] exp_ppn, input string req);
        lk_vpn = v; lk_asid = a;
        #1;
        check(lk_hit == exp_hit, req, 32'(lk_hit), 32'(exp_hit));
        check(lk_idx == exp_idx && lk_ppn == exp_ppn, req,
              {9'd0, lk_idx, lk_ppn}, {9'd0, exp_idx, exp_ppn});
    endtask

    task automatic rd_check(input logic [31:0] exp, input string req);
        #1;
        check(reg_rd_data == exp, req, reg_rd_data, exp);
    endtask

    task automatic t_reset();
        rd_check(32'h0, "R1 reset register");
        look(20'h100, 8'h05, 0, 3'd0, 20'h0, "R1 reset lookup miss");
    endtask

    task automatic t_lock_fill();
        wr_reg(32'h0000_0001);
        rd_check(32'h0000_0001, "R2 preserve readback");
        fill(20'h100, 8'h05, 20'h00AAA, 0, "R3 no main request in capture");
        rd_check(32'h0400_0001, "R4 victim advanced to 1");
        look(20'h100, 8'h05, 1, 3'd0, 20'h00AAA, "R3 fill at entry 0");
        fill(20'h101, 8'h05, 20'h00BBB, 0, "R3 second fill");
        look(20'h101, 8'h05, 1, 3'd1, 20'h00BBB, "R3 fill at entry 1");
    endtask

    task automatic t_main_fill();
        wr_reg(32'h0800_0000);
        rd_check(32'h0800_0000, "R2 victim 2 preserve clear");
        fill(20'h200, 8'h05, 20'h00CCC, 1, "R5 main request raised");
        look(20'h200, 8'h05, 0, 3'd0, 20'h0, "R5 store untouched");
        rd_check(32'h0800_0000, "R5 victim unchanged");
    endtask

    task automatic t_flush_unlocked();
        flush(2'b01, 20'h100, 8'h05);
        look(20'h100, 8'h05, 1, 3'd0, 20'h00AAA, "R6 entry 0 kept");
        look(20'h101, 8'h05, 1, 3'd1, 20'h00BBB, "R6 entry 1 kept");
        flush(2'b00, 20'h100, 8'h05);
        look(20'h100, 8'h05, 1, 3'd0, 20'h00AAA, "R6 no-op kept entry");
    endtask

    task automatic t_flush_va();
        wr_reg(32'h0800_0001);
        fill(20'h100, 8'h09, 20'h00DDD, 0, "R3 fill entry 2");
        fill(20'h300, 8'h09, 20'h00EEE, 0, "R3 fill entry 3");
        look(20'h100, 8'h04, 0, 3'd0, 20'h0, "R9 identifier mismatch misses");
        flush(2'b10, 20'h100, 8'h00);
        look(20'h100, 8'h05, 0, 3'd0, 20'h0, "R7 page flush asid 5");
        look(20'h100, 8'h09, 0, 3'd0, 20'h0, "R7 page flush asid 9");
        look(20'h101, 8'h05, 1, 3'd1, 20'h00BBB, "R7 other page kept");
        look(20'h300, 8'h09, 1, 3'd3, 20'h00EEE, "R7 other page kept 2");
    endtask

    task automatic t_flush_asid();
        flush(2'b11, 20'h000, 8'h09);
        look(20'h300, 8'h09, 0, 3'd0, 20'h0, "R8 identifier flushed");
        look(20'h101, 8'h05, 1, 3'd1, 20'h00BBB, "R8 other identifier kept");
    endtask

    task automatic t_priority();
        wr_reg(32'h1400_0001);
        fill(20'h400, 8'h07, 20'h00111, 0, "R3 fill entry 5");
        look(20'h400, 8'h07, 1, 3'd5, 20'h00111, "R3 fill at entry 5");
        wr_reg(32'h0800_0001);
        fill(20'h400, 8'h07, 20'h00222, 0, "R3 fill entry 2 dup");
        look(20'h400, 8'h07, 1, 3'd2, 20'h00222, "R10 lowest index wins");
    endtask

    task automatic t_wrap();
        wr_reg(32'h1C00_0001);
        fill(20'h500, 8'h03, 20'h00333, 0, "R3 fill entry 7");
        rd_check(32'h0000_0001, "R4 victim wraps to 0");
        look(20'h500, 8'h03, 1, 3'd7, 20'h00333, "R3 fill at entry 7");
        fill(20'h600, 8'h03, 20'h00444, 0, "R4 fill after wrap");
        look(20'h600, 8'h03, 1, 3'd0, 20'h00444, "R4 wrapped fill at entry 0");
        rd_check(32'h0400_0001, "R4 victim 1 after wrap");
    endtask

    task automatic t_same_cycle();
        reg_wr_en = 1; reg_wr_data = 32'h0C00_0000;
        fill_valid = 1; fill_vpn = 20'h700; fill_asid = 8'h01; fill_ppn = 20'h00555;
        tick();
        reg_wr_en = 0; fill_valid = 0;
        rd_check(32'h0C00_0000, "R11 written victim wins");
        look(20'h700, 8'h01, 1, 3'd1, 20'h00555, "R11 fill used old victim");
    endtask

    initial begin
        idle_inputs();
        lk_vpn = '0; lk_asid = '0;
        rst_n = 0;
        @(negedge clk);
        tick();
        rst_n = 1;
        t_reset();
        t_lock_fill();
        t_main_fill();
        t_flush_unlocked();
        t_flush_va();
        t_flush_asid();
        t_priority();
        t_wrap();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule